// File: doc/BRIEF.md
# Serial Configuration Image Reader

The block is the master side of a Microwire link to a 64x16 serial EEPROM. It leaves reset and, without any request, reads the first 16 words of the device (32 bytes) one read command at a time, driving select, clock and data-in and sampling data-out. The bytes are held in a small register image, two per word with the high byte at the even index.

Once all words are in, the block folds the bytes of a key window together with XOR and compares the result against a checksum byte. On a match the 6-byte station address at a fixed offset is presented as a 48-bit value. The image can be read at any time through a random-access byte port. Another pass is started by asserting reset again.

The controller has the states ST_SEL_LOW, ST_SEL_HIGH, ST_LEAD, ST_CMD, ST_TURN, ST_DATA, ST_DESEL, ST_SUM, ST_JUDGE and ST_DONE. All serial states advance on the end of a step of HALF_DIV clocks:

- ST_SEL_LOW goes to ST_SEL_HIGH, then to ST_LEAD (the dummy clock pulse), then to ST_CMD.
- ST_CMD spends a low half and a high half on each of 9 bits, then moves to ST_TURN.
- ST_TURN goes to ST_DATA, which spends a high half and a low half on each of 16 bits.
- ST_DATA then moves to ST_DESEL. From ST_DESEL the block returns to ST_SEL_LOW for the next word, or goes to ST_SUM after the last word.
- ST_SUM takes one clock per key byte. ST_JUDGE takes one clock, and ST_DONE holds until reset.

Top module: `cfg_image_reader`

## Requirements
- R1: While reset is asserted, ser_sel, ser_clk, ser_mosi, done and cksum_ok are 0, station_addr is 0 and every image byte reads back as 0.
- R2: After reset is released the block issues exactly one read command per word, for word addresses 0 to 15 in ascending order, without any start request.
- R3: Each word begins with one step with select low, then one step with select high and clock low. Next comes a single clock pulse with data-in 0. The 9 command bits follow: start 1, opcode 1 then 0, then the 6-bit word address MSB first.
- R4: The serial clock is high only while select is high, and data-in never changes on a rising clock edge; each bit is set up during the preceding clock-low step.
- R5: Every step lasts HALF_DIV clocks, so each clock-high pulse is exactly HALF_DIV cycles long, and a full load produces 416 clock pulses.
- R6: After the address, one step is spent with select high and clock low. Then 16 pulses are given, and data-out is taken once per pulse after the clock has fallen, MSB first. The first 8 bits form byte 2n and the last 8 form byte 2n+1. Select drops after each word.
- R7: rd_data shows the stored byte at index rd_addr combinationally.
- R8: cksum_ok is 1 exactly when the XOR of bytes KEY_START to CKSUM_AT-1 (defaults 0 to 5) equals byte CKSUM_AT (default 6). Bytes outside that window have no effect on it.
- R9: When the checksum matches, station_addr holds bytes ADDR_AT to ADDR_AT+5 (default 16 to 21), with byte ADDR_AT in bits 47:40. On a mismatch it is 0.
- R10: done rises when the check completes and stays high until reset, with select and clock held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; release starts a load |
| ser_miso | input | 1 | Serial data from the EEPROM |
| rd_addr | input | 5 | Byte index for the image read port |
| ser_sel | output | 1 | EEPROM chip select, active high |
| ser_clk | output | 1 | Serial clock |
| ser_mosi | output | 1 | Serial data to the EEPROM |
| done | output | 1 | Load and check finished |
| cksum_ok | output | 1 | Checksum matched |
| station_addr | output | 48 | Station address, zero unless checksum matched |
| rd_data | output | 8 | Image byte at rd_addr |

## Verification
The hardest situations to reach are the two outcomes of the check. The first is a mismatch, which must clear the address output. The second is a match that has to ignore bytes lying just past the key window. Neither can be forced at the ports, because they depend only on what the serial device returns. The bench therefore uses a behavioural EEPROM that decodes each command from the pins and answers from a word array it preloads. It runs three images: one consistent, one with a single flipped checksum bit, and one with a zero key window surrounded by non-zero bytes.

// File: rtl/cir_pkg.sv
`timescale 1ns/1ps
package cir_pkg;
    typedef enum logic [3:0] {
        ST_SEL_LOW,
        ST_SEL_HIGH,
        ST_LEAD,
        ST_CMD,
        ST_TURN,
        ST_DATA,
        ST_DESEL,
        ST_SUM,
        ST_JUDGE,
        ST_DONE
    } cir_state_e;

    // start bit followed by the two-bit read opcode
    localparam logic [2:0] READ_PREFIX = 3'b110;
    localparam int         WORD_BITS   = 16;
    localparam int         SA_BYTES    = 6;
endpackage

// File: rtl/cir_step_timer.sv
`timescale 1ns/1ps
module cir_step_timer #(
    parameter int HALF_DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic step_end
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign step_end = run && (cnt == LAST);
endmodule

// File: rtl/cir_image_store.sv
`timescale 1ns/1ps
module cir_image_store #(
    parameter int IMG_BYTES = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [$clog2(IMG_BYTES/2)-1:0] wr_word_idx,
    input  logic [15:0]                wr_word,
    input  logic [$clog2(IMG_BYTES)-1:0]   rd_addr,
    output logic [7:0]                 rd_data,
    output logic [IMG_BYTES*8-1:0]     img_flat
);
    localparam int WI_W = $clog2(IMG_BYTES/2);

    for (genvar b = 0; b < IMG_BYTES; b++) begin : g_byte
        logic [7:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= '0;
            else if (wr_en && wr_word_idx == WI_W'(b / 2))
                q <= ((b % 2) == 0) ? wr_word[15:8] : wr_word[7:0];
        end
        assign img_flat[b*8 +: 8] = q;
    end

    assign rd_data = img_flat[{rd_addr, 3'b000} +: 8];
endmodule

// File: rtl/cir_xor_acc.sv
`timescale 1ns/1ps
module cir_xor_acc #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] acc
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc <= '0;
        else if (clear)
            acc <= '0;
        else if (en)
            acc <= acc ^ din;
    end
endmodule

// File: rtl/cfg_image_reader.sv
`timescale 1ns/1ps
module cfg_image_reader
    import cir_pkg::*;
#(
    parameter int HALF_DIV  = 50,
    parameter int IMG_BYTES = 32,
    parameter int ADDR_W    = 6,
    parameter int KEY_START = 0,
    parameter int CKSUM_AT  = 6,
    parameter int ADDR_AT   = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ser_miso,
    input  logic [$clog2(IMG_BYTES)-1:0] rd_addr,
    output logic                         ser_sel,
    output logic                         ser_clk,
    output logic                         ser_mosi,
    output logic                         done,
    output logic                         cksum_ok,
    output logic [8*SA_BYTES-1:0]        station_addr,
    output logic [7:0]                   rd_data
);
    localparam int WORDS    = IMG_BYTES / 2;
    localparam int WI_W     = $clog2(WORDS);
    localparam int AW       = $clog2(IMG_BYTES);
    localparam int CMD_BITS = 3 + ADDR_W;
    localparam int BC_MAX   = (CMD_BITS > WORD_BITS) ? CMD_BITS : WORD_BITS;
    localparam int BC_W     = $clog2(BC_MAX);

    cir_state_e            state;
    logic                  half;      // 1: clock-high half of a bit
    logic [BC_W-1:0]       bitcnt;
    logic [WI_W-1:0]       word_idx;
    logic [WORD_BITS-1:0]  shreg;
    logic [AW-1:0]         sum_idx;
    logic                  step_end;
    logic                  run;
    logic                  wr_en;
    logic                  acc_clear;
    logic                  acc_en;
    logic [7:0]            acc;
    logic [7:0]            sum_byte;
    logic [7:0]            ref_byte;
    logic [IMG_BYTES*8-1:0] img_flat;
    logic [CMD_BITS-1:0]   cmd_vec;
    logic [8*SA_BYTES-1:0] sa_pick;
    logic                  ok_q;
    logic [8*SA_BYTES-1:0] sa_q;

    assign cmd_vec  = {READ_PREFIX, ADDR_W'(word_idx)};
    assign sum_byte = img_flat[{sum_idx, 3'b000} +: 8];
    assign ref_byte = img_flat[CKSUM_AT*8 +: 8];

    always_comb begin
        for (int k = 0; k < SA_BYTES; k++)
            sa_pick[8*(SA_BYTES-1-k) +: 8] = img_flat[(ADDR_AT+k)*8 +: 8];
    end

    cir_step_timer #(.HALF_DIV(HALF_DIV)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .step_end (step_end)
    );

    cir_image_store #(.IMG_BYTES(IMG_BYTES)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_word_idx (word_idx),
        .wr_word     (shreg),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .img_flat    (img_flat)
    );

    cir_xor_acc #(.W(8)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (acc_clear),
        .en    (acc_en),
        .din   (sum_byte),
        .acc   (acc)
    );

    // state register and sequencing counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_SEL_LOW;
            half     <= 1'b0;
            bitcnt   <= '0;
            word_idx <= '0;
            shreg    <= '0;
            sum_idx  <= AW'(KEY_START);
        end else begin
            unique case (state)
                ST_SEL_LOW: begin
                    if (step_end) state <= ST_SEL_HIGH;
                end
                ST_SEL_HIGH: begin
                    if (step_end) state <= ST_LEAD;
                end
                ST_LEAD: begin
                    if (step_end) begin
                        state  <= ST_CMD;
                        half   <= 1'b0;
                        bitcnt <= '0;
                    end
                end
                ST_CMD: begin
                    if (step_end) begin
                        if (!half) begin
                            half <= 1'b1;
                        end else if (bitcnt == BC_W'(CMD_BITS - 1)) begin
                            state <= ST_TURN;
                            half  <= 1'b0;
                        end else begin
                            bitcnt <= bitcnt + 1'b1;
                            half   <= 1'b0;
                        end
                    end
                end
                ST_TURN: begin
                    if (step_end) begin
                        state  <= ST_DATA;
                        half   <= 1'b1;
                        bitcnt <= '0;
                    end
                end
                ST_DATA: begin
                    if (step_end) begin
                        if (half) begin
                            half <= 1'b0;
                        end else begin
                            shreg <= {shreg[WORD_BITS-2:0], ser_miso};
                            if (bitcnt == BC_W'(WORD_BITS - 1)) begin
                                state <= ST_DESEL;
                            end else begin
                                bitcnt <= bitcnt + 1'b1;
                                half   <= 1'b1;
                            end
                        end
                    end
                end
                ST_DESEL: begin
                    if (step_end) begin
                        if (word_idx == WI_W'(WORDS - 1)) begin
                            state   <= ST_SUM;
                            sum_idx <= AW'(KEY_START);
                        end else begin
                            word_idx <= word_idx + 1'b1;
                            state    <= ST_SEL_LOW;
                        end
                    end
                end
                ST_SUM: begin
                    if (sum_idx == AW'(CKSUM_AT - 1))
                        state <= ST_JUDGE;
                    else
                        sum_idx <= sum_idx + 1'b1;
                end
                ST_JUDGE: state <= ST_DONE;
                ST_DONE:  state <= ST_DONE;
                default:  state <= ST_SEL_LOW;
            endcase
        end
    end

    // outputs decoded from the state
    always_comb begin
        ser_sel   = 1'b0;
        ser_clk   = 1'b0;
        ser_mosi  = 1'b0;
        run       = 1'b1;
        wr_en     = 1'b0;
        acc_clear = 1'b0;
        acc_en    = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_SEL_LOW:  ;
            ST_SEL_HIGH: ser_sel = 1'b1;
            ST_LEAD: begin
                ser_sel = 1'b1;
                ser_clk = 1'b1;
            end
            ST_CMD: begin
                ser_sel  = 1'b1;
                ser_clk  = half;
                ser_mosi = cmd_vec[BC_W'(CMD_BITS - 1) - bitcnt];
            end
            ST_TURN: ser_sel = 1'b1;
            ST_DATA: begin
                ser_sel = 1'b1;
                ser_clk = half;
            end
            ST_DESEL: begin
                wr_en     = step_end;
                acc_clear = 1'b1;
            end
            ST_SUM: begin
                run    = 1'b0;
                acc_en = 1'b1;
            end
            ST_JUDGE: run = 1'b0;
            ST_DONE: begin
                run  = 1'b0;
                done = 1'b1;
            end
            default: run = 1'b0;
        endcase
    end

    // check result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ok_q <= 1'b0;
            sa_q <= '0;
        end else if (state == ST_JUDGE) begin
            ok_q <= (acc == ref_byte);
            sa_q <= (acc == ref_byte) ? sa_pick : '0;
        end
    end

    assign cksum_ok     = ok_q;
    assign station_addr = sa_q;
endmodule

// File: rtl/cir_reader_checker.sv
`timescale 1ns/1ps
module cir_reader_checker #(
    parameter int HALF_DIV = 50
) (
    input logic        clk,
    input logic        rst_n,
    input logic        ser_sel,
    input logic        ser_clk,
    input logic        ser_mosi,
    input logic        done,
    input logic        cksum_ok,
    input logic [47:0] station_addr
);
    int unsigned hi_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hi_run <= 0;
        else if (ser_clk)
            hi_run <= hi_run + 1;
        else
            hi_run <= 0;
    end

    p_clk_in_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |-> ser_sel);

    p_mosi_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk) |-> $stable(ser_mosi));

    p_pulse_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_clk) |-> (hi_run == HALF_DIV));

    p_ok_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cksum_ok |-> done);

    p_addr_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cksum_ok) |-> (station_addr == 48'h0));

    p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    p_idle_pins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!ser_sel && !ser_clk));
endmodule

bind cfg_image_reader cir_reader_checker #(.HALF_DIV(HALF_DIV)) u_check (
    .clk          (clk),
    .rst_n        (rst_n),
    .ser_sel      (ser_sel),
    .ser_clk      (ser_clk),
    .ser_mosi     (ser_mosi),
    .done         (done),
    .cksum_ok     (cksum_ok),
    .station_addr (station_addr)
);

// File: tb/cfg_image_reader_test.sv
`timescale 1ns/1ps
module cfg_image_reader_test;
    localparam int HD = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_miso = 1'b0;
    logic [4:0]  rd_addr = '0;
    logic        ser_sel, ser_clk, ser_mosi, done, cksum_ok;
    logic [47:0] station_addr;
    logic [7:0]  rd_data;

    always #2.5 clk = ~clk;

    cfg_image_reader #(.HALF_DIV(HD)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ser_miso     (ser_miso),
        .rd_addr      (rd_addr),
        .ser_sel      (ser_sel),
        .ser_clk      (ser_clk),
        .ser_mosi     (ser_mosi),
        .done         (done),
        .cksum_ok     (cksum_ok),
        .station_addr (station_addr),
        .rd_data      (rd_data)
    );

    int total = 0;
    int bad = 0;
    logic [15:0] rom [16];
    logic [7:0]  img [32];
    int exp_q[$];

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // behavioural serial EEPROM acting as the scoreboard monitor
    int m_phase = 0, rise_cnt = 0, nbits = 0, dptr = 0, lead = 0;
    int words_seen = 0;
    logic [7:0]  cmd = '0;
    logic [15:0] dword = '0;

    always @(negedge ser_sel) begin
        if (m_phase == 2) chk("R6", "pulses in data phase", dptr, 16);
        m_phase = 0;
        rise_cnt = 0;
        ser_miso = 1'b0;
        words_seen++;
    end

    always @(posedge ser_clk) begin
        if (ser_sel) begin
            rise_cnt++;
            case (m_phase)
                0: if (ser_mosi) begin
                    lead = rise_cnt - 1;
                    m_phase = 1;
                    nbits = 0;
                    cmd = '0;
                end
                1: begin
                    cmd = {cmd[6:0], ser_mosi};
                    nbits++;
                    if (nbits == 8) begin
                        m_phase = 2;
                        dptr = 0;
                        ser_miso = 1'b0;
                        dword = rom[cmd[3:0]];
                        chk("R3", "leading dummy pulses", lead, 1);
                        chk("R3", "read opcode", cmd[7:6], 2'b10);
                        if (exp_q.size() == 0) begin
                            chk("R2", "unexpected extra command", 1, 0);
                        end else begin
                            int e;
                            e = exp_q.pop_front();
                            chk("R2", "word address order", cmd[5:0], e);
                        end
                    end
                end
                default: begin
                    if (dptr < 16) ser_miso = dword[15 - dptr];
                    dptr++;
                end
            endcase
        end
    end

    int hi_len = 0, pulses = 0, width_bad = 0, sel_bad = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (ser_clk) begin
                hi_len++;
            end else begin
                if (hi_len != 0) begin
                    pulses++;
                    if (hi_len != HD) width_bad++;
                end
                hi_len = 0;
            end
            if (ser_clk && !ser_sel) sel_bad++;
        end
    end

    task automatic run_load(input string tag);
        logic [7:0]  x;
        logic        exp_ok;
        logic [47:0] exp_sa;
        rst_n = 1'b0;
        rd_addr = 5'd6;
        repeat (3) @(negedge clk);
        chk("R1", {tag, " sel in reset"}, ser_sel, 0);
        chk("R1", {tag, " clk/mosi in reset"}, {ser_clk, ser_mosi}, 0);
        chk("R1", {tag, " done/ok in reset"}, {done, cksum_ok}, 0);
        chk("R1", {tag, " station in reset"}, station_addr, 0);
        chk("R1", {tag, " image cleared"}, rd_data, 0);
        for (int n = 0; n < 16; n++) begin
            rom[n] = {img[2*n], img[2*n+1]};
            exp_q.push_back(n);
        end
        words_seen = 0; pulses = 0; width_bad = 0; sel_bad = 0; hi_len = 0;
        @(negedge clk);
        rst_n = 1'b1;
        while (!done) @(negedge clk);
        x = 8'h00;
        for (int i = 0; i < 6; i++) x ^= img[i];
        exp_ok = (x == img[6]);
        exp_sa = exp_ok ? {img[16], img[17], img[18], img[19], img[20], img[21]} : 48'h0;
        chk("R10", {tag, " done"}, done, 1);
        chk("R8", {tag, " checksum result"}, cksum_ok, exp_ok);
        chk("R9", {tag, " station address"}, station_addr, exp_sa);
        chk("R2", {tag, " all commands issued"}, exp_q.size(), 0);
        chk("R6", {tag, " select drops per word"}, words_seen, 16);
        chk("R5", {tag, " pulse widths"}, width_bad, 0);
        chk("R5", {tag, " pulse count"}, pulses, 416);
        chk("R4", {tag, " clock outside select"}, sel_bad, 0);
        for (int i = 0; i < 32; i++) begin
            rd_addr = 5'(i);
            #1;
            chk("R7", {tag, " image byte"}, rd_data, img[i]);
        end
        repeat (20) @(negedge clk);
        chk("R10", {tag, " done held"}, done, 1);
        chk("R10", {tag, " pins idle"}, {ser_sel, ser_clk}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] x;
        // image A: consistent checksum
        for (int i = 0; i < 32; i++) img[i] = 8'(i * 37 + 5);
        x = 8'h00;
        for (int i = 0; i < 6; i++) x ^= img[i];
        img[6] = x;
        img[16] = 8'h02; img[17] = 8'h00; img[18] = 8'h4C;
        img[19] = 8'h5A; img[20] = 8'h33; img[21] = 8'hC1;
        run_load("A");
        // image B: one checksum bit flipped
        img[6] = img[6] ^ 8'h40;
        run_load("B");
        // image C: zero key window, busy neighbours
        for (int i = 0; i < 32; i++) img[i] = 8'(8'hF0 | i);
        for (int i = 0; i < 6; i++) img[i] = 8'h00;
        img[6] = 8'h00;
        img[16] = 8'hA5; img[17] = 8'h5A; img[18] = 8'h01;
        img[19] = 8'h80; img[20] = 8'h7E; img[21] = 8'hE7;
        run_load("C");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule